// File: doc/BRIEF.md
# Doorbell Mailbox Console Bridge

This block moves a byte-wide console stream between a host and a local processor using two 32-bit mailbox words and a doorbell word in each direction. The local side hands in characters for the host through a valid/ready port and takes host characters out of a 256-entry ring through a second valid/ready port. The host side is shown as plain register strobes. The host can write the receive mailbox, ring the incoming doorbell with a message code and clear the transmit mailbox once it has read it. It sees the outgoing doorbell as a code register with a one-cycle post pulse.

A host doorbell raises `irq` for one cycle. In the next clock edge the bridge decodes the code, acts on it and wipes the doorbell register by writing all ones to it. Flow control needs no extra signal. After each stored character the receive mailbox is cleared, which is the host's cue to send again. When the ring is nearly full the mailbox is left holding the last character. It is released only when the local reader has drained enough entries.

Top module: `mbox_console_bridge`

## Requirements
- R1: After reset both mailboxes read zero, `irq`, `rxValid`, `outDbPost` and `linkUp` are low, and `txReady` is high.
- R2: A local character is accepted only while the transmit mailbox reads zero. On acceptance the mailbox becomes the character in bits 7:0 with bit 31 set and all other bits zero. In the same edge the outgoing doorbell posts code 0x5. While the mailbox is non-zero, `txReady` is low and `txValid` has no effect.
- R3: An accepted line feed (0x0A) is followed by a carriage return (0x0D). The bridge sends it by itself, with doorbell code 0x5, on the edge after the host has cleared the transmit mailbox. `txReady` stays low until then.
- R4: Host doorbell code 0x1 is answered by posting code 0x1 on the outgoing doorbell.
- R5: Host doorbell code 0x2 empties the ring (both pointers to zero, so `rxValid` drops), clears the full flag and the receive mailbox, and raises `linkUp`.
- R6: Host doorbell code 0x5 stores bits 7:0 of the receive mailbox into the ring. The local reader gets the characters in arrival order on `rxChar`, and one is popped on each edge where `rxValid` and `rxReady` are both high. Pointers wrap modulo 256, and the ring is empty when they are equal.
- R7: If a store leaves at most 252 entries in the ring, the receive mailbox is cleared on that same edge.
- R8: If a store leaves more than 252 entries, the receive mailbox keeps its value and the full flag is set.
- R9: While the full flag is set, a pop that leaves fewer than 252 entries clears the flag and the receive mailbox. A pop that leaves exactly 252 entries clears neither.
- R10: A host doorbell write sets `irq` on the next edge. The bridge clears it on the edge after that. A code other than 0x1, 0x2 or 0x5 is cleared the same way and changes nothing else: no post, no ring change, no mailbox change.
- R11: A pulse on `discReq` posts code 0x3 on the outgoing doorbell two edges later and drops `linkUp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostDbWr | input | 1 | Host rings the incoming doorbell |
| hostDbCode | input | 32 | Bits ORed into the incoming doorbell |
| hostRxMbWr | input | 1 | Host writes the receive mailbox |
| hostRxMbData | input | 32 | Receive mailbox write data |
| hostTxMbClr | input | 1 | Host clears the transmit mailbox after reading it |
| rxMbox | output | 32 | Receive mailbox contents |
| txMbox | output | 32 | Transmit mailbox contents |
| outDbPost | output | 1 | One-cycle pulse when a code is posted to the host |
| outDbCode | output | 32 | Last code posted to the host |
| irq | output | 1 | Incoming doorbell pending |
| txValid | input | 1 | Local character offered |
| txChar | input | 8 | Local character to send |
| txReady | output | 1 | Bridge can take a local character |
| rxValid | output | 1 | Ring holds a character |
| rxChar | output | 8 | Oldest character in the ring |
| rxReady | input | 1 | Local reader takes the character |
| discReq | input | 1 | Request to post a disconnect |
| linkUp | output | 1 | Host has connected |

## Verification
The receive path is driven with mailbox words whose upper 24 bits carry assorted junk. This shows that only the low byte reaches the ring and that arrival order is kept. The ring is then filled to 253 entries and drained by two entries. The change in the mailbox shows where the release threshold lies, and one pop tells 252 apart from 251. On the transmit side, an ordinary character is compared with a line feed to tell an automatic carriage return from a plain send. A retry while the mailbox is busy shows that back-pressure holds. A known doorbell code and an unknown one are compared so that a real action can be told apart from a plain clear.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
  localparam int WORD_W = 32;
  localparam int CHAR_W = 8;

  localparam logic [WORD_W-1:0] MSG_ALIVE   = WORD_W'(32'h1);
  localparam logic [WORD_W-1:0] MSG_CONNECT = WORD_W'(32'h2);
  localparam logic [WORD_W-1:0] MSG_DISC    = WORD_W'(32'h3);
  localparam logic [WORD_W-1:0] MSG_DATA    = WORD_W'(32'h5);

  localparam logic [CHAR_W-1:0] CH_LF = 8'h0A;
  localparam logic [CHAR_W-1:0] CH_CR = 8'h0D;

  // strobes from the control unit to the datapath, at most one action per cycle
  typedef struct packed {
    logic              clrInDb;
    logic              doConnect;
    logic              doStore;
    logic              loadTx;
    logic [CHAR_W-1:0] txByte;
    logic              post;
    logic [WORD_W-1:0] postCode;
    logic              linkDown;
  } mcbStrobe_t;
endpackage

// File: rtl/mcb_ctrl.sv
module mcb_ctrl
  import mcb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] inDb,
  input  logic              txIdle,
  input  logic              txValid,
  input  logic [CHAR_W-1:0] txChar,
  input  logic              discReq,
  output logic              txReady,
  output mcbStrobe_t        strobes
);
  logic crPend;
  logic discPend;
  logic dbBusy;

  assign dbBusy = |inDb;

  // priority: host doorbell, disconnect, pending carriage return, new character
  always_comb begin
    strobes = '0;
    txReady = 1'b0;
    if (dbBusy) begin
      strobes.clrInDb = 1'b1;
      case (inDb)
        MSG_ALIVE: begin
          strobes.post     = 1'b1;
          strobes.postCode = MSG_ALIVE;
        end
        MSG_CONNECT: strobes.doConnect = 1'b1;
        MSG_DATA:    strobes.doStore   = 1'b1;
        default: ;
      endcase
    end else if (discPend) begin
      strobes.post     = 1'b1;
      strobes.postCode = MSG_DISC;
      strobes.linkDown = 1'b1;
    end else if (crPend) begin
      if (txIdle) begin
        strobes.loadTx   = 1'b1;
        strobes.txByte   = CH_CR;
        strobes.post     = 1'b1;
        strobes.postCode = MSG_DATA;
      end
    end else begin
      txReady = txIdle;
      if (txValid && txIdle) begin
        strobes.loadTx   = 1'b1;
        strobes.txByte   = txChar;
        strobes.post     = 1'b1;
        strobes.postCode = MSG_DATA;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crPend   <= 1'b0;
      discPend <= 1'b0;
    end else begin
      if (strobes.loadTx) crPend <= (strobes.txByte == CH_LF) && !crPend;
      discPend <= discReq || (discPend && !strobes.linkDown);
    end
  end
endmodule

// File: rtl/mcb_datapath.sv
module mcb_datapath
  import mcb_pkg::*;
#(
  parameter int RING_LOG2 = 8,
  parameter int MARGIN    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  mcbStrobe_t        strobes,
  input  logic              hostDbWr,
  input  logic [WORD_W-1:0] hostDbCode,
  input  logic              hostRxMbWr,
  input  logic [WORD_W-1:0] hostRxMbData,
  input  logic              hostTxMbClr,
  input  logic              rxReady,
  output logic [WORD_W-1:0] inDb,
  output logic [WORD_W-1:0] rxMbox,
  output logic [WORD_W-1:0] txMbox,
  output logic              txIdle,
  output logic              outDbPost,
  output logic [WORD_W-1:0] outDbCode,
  output logic              linkUp,
  output logic              rxValid,
  output logic [CHAR_W-1:0] rxChar
);
  localparam int RING_SIZE   = 1 << RING_LOG2;
  localparam int HIGH_MARK_I = RING_SIZE - MARGIN;
  localparam logic [RING_LOG2:0] HIGH_MARK = HIGH_MARK_I[RING_LOG2:0];
  localparam logic [WORD_W-1:0]  ALL_ONES  = '1;

  logic [CHAR_W-1:0]    ring [RING_SIZE];
  logic [RING_LOG2-1:0] wrPtr, rdPtr, occLow;
  logic [RING_LOG2:0]   occ, newOcc;
  logic                 fullFlag;
  logic                 pop;
  logic                 setFull, releaseFull, clrRx;

  assign txIdle  = (txMbox == '0);
  assign rxValid = (wrPtr != rdPtr);
  assign rxChar  = ring[rdPtr];
  assign pop     = rxValid && rxReady;
  assign occLow  = wrPtr - rdPtr;
  assign occ     = {1'b0, occLow};
  assign newOcc  = occ + {{RING_LOG2{1'b0}}, strobes.doStore}
                       - {{RING_LOG2{1'b0}}, pop};

  always_comb begin
    setFull     = strobes.doStore && (newOcc > HIGH_MARK);
    releaseFull = fullFlag && pop && (newOcc < HIGH_MARK);
    clrRx       = strobes.doConnect || releaseFull ||
                  (strobes.doStore && !setFull);
  end

  always_ff @(posedge clk) begin
    if (strobes.doStore) ring[wrPtr] <= rxMbox[CHAR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inDb      <= '0;
      rxMbox    <= '0;
      txMbox    <= '0;
      outDbPost <= 1'b0;
      outDbCode <= '0;
      linkUp    <= 1'b0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      fullFlag  <= 1'b0;
    end else begin
      // clearing the doorbell is a write of all ones, write-one-to-clear
      inDb <= (inDb & ~(strobes.clrInDb ? ALL_ONES : '0)) |
              (hostDbWr ? hostDbCode : '0);

      if (hostRxMbWr)  rxMbox <= hostRxMbData;
      else if (clrRx)  rxMbox <= '0;

      if (strobes.loadTx)
        txMbox <= {1'b1, {(WORD_W-1-CHAR_W){1'b0}}, strobes.txByte};
      else if (hostTxMbClr)
        txMbox <= '0;

      outDbPost <= strobes.post;
      if (strobes.post) outDbCode <= strobes.postCode;

      if (strobes.doConnect)     linkUp <= 1'b1;
      else if (strobes.linkDown) linkUp <= 1'b0;

      if (strobes.doConnect) begin
        wrPtr    <= '0;
        rdPtr    <= '0;
        fullFlag <= 1'b0;
      end else begin
        if (strobes.doStore) wrPtr <= wrPtr + 1'b1;
        if (pop)             rdPtr <= rdPtr + 1'b1;
        if (setFull)          fullFlag <= 1'b1;
        else if (releaseFull) fullFlag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mbox_console_bridge.sv
module mbox_console_bridge
  import mcb_pkg::*;
#(
  parameter int RING_LOG2 = 8,
  parameter int MARGIN    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostDbWr,
  input  logic [WORD_W-1:0] hostDbCode,
  input  logic              hostRxMbWr,
  input  logic [WORD_W-1:0] hostRxMbData,
  input  logic              hostTxMbClr,
  output logic [WORD_W-1:0] rxMbox,
  output logic [WORD_W-1:0] txMbox,
  output logic              outDbPost,
  output logic [WORD_W-1:0] outDbCode,
  output logic              irq,
  input  logic              txValid,
  input  logic [CHAR_W-1:0] txChar,
  output logic              txReady,
  output logic              rxValid,
  output logic [CHAR_W-1:0] rxChar,
  input  logic              rxReady,
  input  logic              discReq,
  output logic              linkUp
);
  mcbStrobe_t        strobes;
  logic [WORD_W-1:0] inDb;
  logic              txIdle;

  assign irq = |inDb;

  mcb_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inDb    (inDb),
    .txIdle  (txIdle),
    .txValid (txValid),
    .txChar  (txChar),
    .discReq (discReq),
    .txReady (txReady),
    .strobes (strobes)
  );

  mcb_datapath #(.RING_LOG2(RING_LOG2), .MARGIN(MARGIN)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .hostDbWr     (hostDbWr),
    .hostDbCode   (hostDbCode),
    .hostRxMbWr   (hostRxMbWr),
    .hostRxMbData (hostRxMbData),
    .hostTxMbClr  (hostTxMbClr),
    .rxReady      (rxReady),
    .inDb         (inDb),
    .rxMbox       (rxMbox),
    .txMbox       (txMbox),
    .txIdle       (txIdle),
    .outDbPost    (outDbPost),
    .outDbCode    (outDbCode),
    .linkUp       (linkUp),
    .rxValid      (rxValid),
    .rxChar       (rxChar)
  );
endmodule

// File: rtl/mcb_checker.sv
module mcb_checker (
  input logic        clk,
  input logic        rstN,
  input logic        hostDbWr,
  input logic [31:0] hostDbCode,
  input logic [31:0] txMbox,
  input logic        outDbPost,
  input logic [31:0] outDbCode,
  input logic        irq,
  input logic        txValid,
  input logic [7:0]  txChar,
  input logic        txReady,
  input logic        rxValid,
  input logic        linkUp
);
  // R2
  tx_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> (txMbox == {24'h800000, $past(txChar)} &&
                              outDbPost && outDbCode == 32'h5));

  // R2
  tx_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txMbox != 32'h0) |-> !txReady);

  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostDbWr && hostDbCode != 32'h0) |=> irq);

  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !hostDbWr) |=> !irq);

  // R4
  alive_reply_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostDbWr && hostDbCode == 32'h1 && !irq) |=> ##1 (outDbPost && outDbCode == 32'h1));

  // R5
  connect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostDbWr && hostDbCode == 32'h2 && !irq) |=> ##1 (linkUp && !rxValid));

  // R11
  disc_link_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outDbPost && outDbCode == 32'h3) |-> !linkUp);
endmodule

bind mbox_console_bridge mcb_checker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .hostDbWr   (hostDbWr),
  .hostDbCode (hostDbCode),
  .txMbox     (txMbox),
  .outDbPost  (outDbPost),
  .outDbCode  (outDbCode),
  .irq        (irq),
  .txValid    (txValid),
  .txChar     (txChar),
  .txReady    (txReady),
  .rxValid    (rxValid),
  .linkUp     (linkUp)
);

// File: tb/tb_mbox_console_bridge.sv
module tb_mbox_console_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  // column 39:32 expected character, 31:0 mailbox word written by host
  localparam logic [39:0] RX_VEC [8] = '{
    {8'h41, 32'h0000_0041}, {8'h42, 32'hABCD_0042},
    {8'hFF, 32'h8000_00FF}, {8'h01, 32'h1234_5601},
    {8'h0A, 32'h0000_FF0A}, {8'h7E, 32'hFFFF_FF7E},
    {8'h80, 32'h0000_0180}, {8'h20, 32'h5A5A_5A20}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostDbWr = 1'b0;
  logic [31:0] hostDbCode = '0;
  logic        hostRxMbWr = 1'b0;
  logic [31:0] hostRxMbData = '0;
  logic        hostTxMbClr = 1'b0;
  logic        txValid = 1'b0;
  logic [7:0]  txChar = '0;
  logic        rxReady = 1'b0;
  logic        discReq = 1'b0;
  logic [31:0] rxMbox, txMbox, outDbCode;
  logic        outDbPost, irq, txReady, rxValid, linkUp;
  logic [7:0]  rxChar;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_console_bridge dut (
    .clk(clk), .rstN(rstN), .hostDbWr(hostDbWr), .hostDbCode(hostDbCode),
    .hostRxMbWr(hostRxMbWr), .hostRxMbData(hostRxMbData), .hostTxMbClr(hostTxMbClr),
    .rxMbox(rxMbox), .txMbox(txMbox), .outDbPost(outDbPost), .outDbCode(outDbCode),
    .irq(irq), .txValid(txValid), .txChar(txChar), .txReady(txReady),
    .rxValid(rxValid), .rxChar(rxChar), .rxReady(rxReady), .discReq(discReq),
    .linkUp(linkUp)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // host rings the doorbell (optionally writing the mailbox in the same cycle);
  // returns at the negedge after the bridge has acted
  task automatic ringBell(input logic [31:0] code, input logic mbWr, input logic [31:0] word);
    @(negedge clk);
    hostDbWr = 1'b1; hostDbCode = code; hostRxMbWr = mbWr; hostRxMbData = word;
    @(negedge clk);
    hostDbWr = 1'b0; hostRxMbWr = 1'b0;
    @(negedge clk);
  endtask

  task automatic hostMbWrite(input logic [31:0] word);
    @(negedge clk);
    hostRxMbWr = 1'b1; hostRxMbData = word;
    @(negedge clk);
    hostRxMbWr = 1'b0;
  endtask

  task automatic popChar(input string tag, input logic [7:0] exp);
    @(negedge clk);
    chk(tag, {24'h0, rxChar}, {24'h0, exp});
    rxReady = 1'b1;
    @(negedge clk);
    rxReady = 1'b0;
  endtask

  task automatic clearTx();
    @(negedge clk);
    hostTxMbClr = 1'b1;
    @(negedge clk);
    hostTxMbClr = 1'b0;
  endtask

  task automatic checkReset();
    chk("R1 txMbox", txMbox, 32'h0);
    chk("R1 rxMbox", rxMbox, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 rxValid", {31'h0, rxValid}, 32'h0);
    chk("R1 outDbPost", {31'h0, outDbPost}, 32'h0);
    chk("R1 linkUp", {31'h0, linkUp}, 32'h0);
    chk("R1 txReady", {31'h0, txReady}, 32'h1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkReset();

    // R5: connect wipes a dirty receive mailbox
    hostMbWrite(32'h55);
    ringBell(32'h2, 1'b0, 32'h0);
    chk("R5 linkUp", {31'h0, linkUp}, 32'h1);
    chk("R5 rxMbox cleared", rxMbox, 32'h0);
    chk("R5 ring empty", {31'h0, rxValid}, 32'h0);

    // R6 / R7: vector table through the receive path
    for (int i = 0; i < 8; i++) begin
      ringBell(32'h5, 1'b1, RX_VEC[i][31:0]);
      chk("R7 mailbox released", rxMbox, 32'h0);
    end
    for (int i = 0; i < 8; i++) popChar("R6 ring order", RX_VEC[i][39:32]);
    @(negedge clk);
    chk("R6 ring empty", {31'h0, rxValid}, 32'h0);

    // R2: plain transmit and back-pressure
    txValid = 1'b1; txChar = 8'h41;
    chk("R2 ready when idle", {31'h0, txReady}, 32'h1);
    @(negedge clk);
    chk("R2 tx mailbox", txMbox, 32'h8000_0041);
    chk("R2 post", {31'h0, outDbPost}, 32'h1);
    chk("R2 post code", outDbCode, 32'h5);
    chk("R2 busy", {31'h0, txReady}, 32'h0);
    txChar = 8'h42;
    @(negedge clk);
    chk("R2 busy ignores tx", txMbox, 32'h8000_0041);
    txValid = 1'b0;
    clearTx();
    chk("R2 ready again", {31'h0, txReady}, 32'h1);

    // R3: line feed followed by automatic carriage return
    @(negedge clk);
    txValid = 1'b1; txChar = 8'h0A;
    @(negedge clk);
    txValid = 1'b0;
    chk("R3 lf sent", txMbox, 32'h8000_000A);
    hostTxMbClr = 1'b1;
    @(negedge clk);
    hostTxMbClr = 1'b0;
    chk("R3 ready held low", {31'h0, txReady}, 32'h0);
    @(negedge clk);
    chk("R3 cr sent", txMbox, 32'h8000_000D);
    chk("R3 cr post", {31'h0, outDbPost}, 32'h1);
    chk("R3 cr code", outDbCode, 32'h5);
    clearTx();
    chk("R3 ready after cr", {31'h0, txReady}, 32'h1);

    // R4 / R10: alive reply and interrupt timing
    @(negedge clk);
    hostDbWr = 1'b1; hostDbCode = 32'h1;
    @(negedge clk);
    hostDbWr = 1'b0;
    chk("R10 irq raised", {31'h0, irq}, 32'h1);
    @(negedge clk);
    chk("R10 irq cleared", {31'h0, irq}, 32'h0);
    chk("R4 alive post", {31'h0, outDbPost}, 32'h1);
    chk("R4 alive code", outDbCode, 32'h1);

    // R10: unknown code only clears
    hostMbWrite(32'h66);
    ringBell(32'h7, 1'b0, 32'h0);
    chk("R10 unknown irq cleared", {31'h0, irq}, 32'h0);
    chk("R10 unknown no post", {31'h0, outDbPost}, 32'h0);
    chk("R10 unknown code kept", outDbCode, 32'h1);
    chk("R10 unknown ring", {31'h0, rxValid}, 32'h0);
    chk("R10 unknown mailbox", rxMbox, 32'h66);
    hostMbWrite(32'h0);

    // R7 / R8 / R9: flow control threshold
    for (int i = 0; i < 252; i++) ringBell(32'h5, 1'b1, 32'h100 + i);
    chk("R7 at 252 released", rxMbox, 32'h0);
    ringBell(32'h5, 1'b1, 32'h1FD);
    chk("R8 at 253 held", rxMbox, 32'h1FD);
    popChar("R6 oldest first", 8'h00);
    chk("R9 at 252 still held", rxMbox, 32'h1FD);
    popChar("R6 second", 8'h01);
    chk("R9 at 251 released", rxMbox, 32'h0);

    // R5: connect empties a populated ring
    ringBell(32'h2, 1'b0, 32'h0);
    chk("R5 ring reset", {31'h0, rxValid}, 32'h0);

    // R11: disconnect
    @(negedge clk);
    discReq = 1'b1;
    @(negedge clk);
    discReq = 1'b0;
    @(negedge clk);
    chk("R11 disc post", {31'h0, outDbPost}, 32'h1);
    chk("R11 disc code", outDbCode, 32'h3);
    chk("R11 link down", {31'h0, linkUp}, 32'h0);

    // R1: reset in the middle of traffic
    ringBell(32'h5, 1'b1, 32'h41);
    chk("R6 stored before reset", {31'h0, rxValid}, 32'h1);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkReset();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule